// File: doc/BRIEF.md
# Address-Generation Interlock Detector

This unit sits in the decode stage of an in-order pipeline. It decides whether the instruction about to enter address generation must wait one cycle. The reason to wait is that a register it needs for forming an address was changed by the instruction accepted in the cycle just before. Each cycle the issuing instruction presents four things:

- whether it forms an address, together with its base and index register numbers;
- whether it uses the stack pointer implicitly;
- its instruction class;
- the set of registers it writes.

The unit answers in the same cycle with a single stall request. While the request is high, the upstream logic holds the instruction and presents it again in the next cycle. During that repeat cycle, the unit treats the slot as a bubble.

The stack pointer gets special treatment. Updates to it made by push, pop, call and plain return are assumed to be handled by separate prediction logic, so they never interlock. Explicit arithmetic or moves on the stack pointer, and returns that release an immediate byte count, do interlock with any following user of the stack pointer.

Top module: `agi_hazard_unit`

## Requirements
- R1: When a valid instruction has `addr_use` high and a valid base or index register that was written by the instruction accepted in the previous cycle, `stall` is high in that same cycle. When `addr_use` is low (and the class is not LEA), or the operand's valid flag is low, that operand causes no stall.
- R2: An instruction of class 4 (LEA) checks its valid base and index registers as in R1, even when `addr_use` is low.
- R3: An instruction of class 0 (ordinary ALU/MOV) that writes the stack pointer (register `SP_ID`, default 4) causes a stall for a following instruction of class 1 (PUSH/POP/CALL), class 2 (RET) or class 3 (RET with immediate), or for one that has `sp_use` high.
- R4: For classes 1 and 2, the stack-pointer bit of `dst_mask` is ignored, so a following stack-pointer user does not stall. Other destination bits of a class 1 instruction are still recorded.
- R5: A plain RET (class 2) followed by an instruction that uses the stack pointer gives no stall.
- R6: A RET with immediate (class 3) counts as a stack-pointer write, whatever its `dst_mask`, and stalls a following stack-pointer user.
- R7: A register written two or more cycles earlier causes no stall. This holds when an invalid slot or an unrelated instruction lies in between.
- R8: A stalled slot is a bubble. The stalled instruction's writes are not recorded, so its repeat in the next cycle does not stall. The writes of that repeat are recorded.
- R9: During and right after reset, nothing is recorded and `stall` is low.
- R10: `stall` is low whenever `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| addr_use | input | 1 | The instruction forms a memory address |
| base_vld | input | 1 | Base register field is in use |
| base_id | input | RID_W | Base register number |
| idx_vld | input | 1 | Index register field is in use |
| idx_id | input | RID_W | Index register number |
| sp_use | input | 1 | Implicit stack pointer read |
| op_class | input | 3 | 0 ALU/MOV, 1 PUSH/POP/CALL, 2 RET, 3 RET imm, 4 LEA |
| dst_mask | input | 2**RID_W | One bit per full register written; any write size sets the bit |
| stall | output | 1 | Hold the instruction one cycle |

## Verification
Two functions can meet in a single cycle. The same instruction may be stalled for an address hazard while it also writes a register that the next instruction reads. The bench provokes this with a load that stalls on its base register and also writes another register. It then checks three things: the stall, a clean repeat of the load in the next cycle, and a stall for the next load that uses the second register. That last result can only come from recording the repeat's writes, not the writes of the bubble.

// File: rtl/agi_hazard_unit.sv
module agi_hazard_unit #(
  parameter int RID_W = 3,
  parameter int SP_ID = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  addr_use,
  input  logic                  base_vld,
  input  logic [RID_W-1:0]      base_id,
  input  logic                  idx_vld,
  input  logic [RID_W-1:0]      idx_id,
  input  logic                  sp_use,
  input  logic [2:0]            op_class,
  input  logic [(1<<RID_W)-1:0] dst_mask,
  output logic                  stall
);
  localparam int NREG = 1 << RID_W;
  localparam logic [2:0] C_STK = 3'd1, C_RET = 3'd2, C_RETI = 3'd3, C_LEA = 3'd4;
  localparam logic [NREG-1:0] ONE = {{(NREG-1){1'b0}}, 1'b1};
  localparam logic [NREG-1:0] SP_OH = ONE << SP_ID;

  logic [NREG-1:0] last_wr, rd_mask, wr_mask;

  wire addr_calc = addr_use || op_class == C_LEA;
  wire sp_impl   = sp_use || op_class == C_STK || op_class == C_RET || op_class == C_RETI;

  assign rd_mask = ((addr_calc && base_vld) ? (ONE << base_id) : '0)
                 | ((addr_calc && idx_vld)  ? (ONE << idx_id)  : '0)
                 | (sp_impl ? SP_OH : '0);

  always_comb begin
    case (op_class)
      C_STK, C_RET: wr_mask = dst_mask & ~SP_OH;
      C_RETI:       wr_mask = dst_mask | SP_OH;
      default:      wr_mask = dst_mask;
    endcase
  end

  assign stall = in_valid && |(rd_mask & last_wr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 last_wr <= '0;
    else if (in_valid && !stall) last_wr <= wr_mask;
    else                        last_wr <= '0;
endmodule

module agi_hazard_chk #(
  parameter int RID_W = 3,
  parameter int SP_ID = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  sp_use,
  input logic [2:0]            op_class,
  input logic [(1<<RID_W)-1:0] dst_mask,
  input logic                  stall
);
  localparam logic [(1<<RID_W)-1:0] SPB = {{((1<<RID_W)-1){1'b0}}, 1'b1} << SP_ID;

  // R8
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n) stall |=> !stall);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |-> !stall);
  // R7
  gap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !stall);
  // R4
  push_sp_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall && op_class == 3'd1 && dst_mask == SPB) |=> !stall);
  // R6
  reti_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall && op_class == 3'd3) ##1 (in_valid && (sp_use || op_class == 3'd1)) |-> stall);
  // R9
  always @(posedge clk) if (!rst_n) reset_quiet_chk: assert (!stall);
endmodule

bind agi_hazard_unit agi_hazard_chk #(.RID_W(RID_W), .SP_ID(SP_ID)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sp_use(sp_use),
  .op_class(op_class), .dst_mask(dst_mask), .stall(stall));

// File: tb/agi_hazard_unit_tb_top.sv
`timescale 1ns/1ps
module agi_hazard_unit_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, addr_use = 0, base_vld = 0, idx_vld = 0, sp_use = 0;
  logic [2:0] base_id = 0, idx_id = 0, op_class = 0;
  logic [7:0] dst_mask = 0;
  logic stall;
  int checks = 0, fails = 0;
  bit exp_q[$];
  string req_q[$];

  always #2.5 clk = ~clk;

  agi_hazard_unit dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr_use(addr_use),
    .base_vld(base_vld), .base_id(base_id), .idx_vld(idx_vld), .idx_id(idx_id),
    .sp_use(sp_use), .op_class(op_class), .dst_mask(dst_mask), .stall(stall));

  task automatic check(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: stall=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic issue(input bit au, input bit bv, input logic [2:0] b, input bit iv,
                       input logic [2:0] ix, input bit sp, input logic [2:0] cls,
                       input logic [7:0] dm, input bit exp, input string req);
    @(negedge clk);
    in_valid = 1; addr_use = au; base_vld = bv; base_id = b; idx_vld = iv; idx_id = ix;
    sp_use = sp; op_class = cls; dst_mask = dm;
    exp_q.push_back(exp); req_q.push_back(req);
    if (exp) begin
      @(negedge clk);
      exp_q.push_back(1'b0); req_q.push_back("R8 repeat");
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  always begin
    @(negedge clk);
    #1;
    if (in_valid) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 1'b1, 1'b0);
      else check(req_q.pop_front(), stall, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 5);
    check("watchdog", 1'b1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1;
    check("R9 in reset", stall, 1'b0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R9 after reset", stall, 1'b0);
    // R1 base and index
    issue(0,0,0,0,0,0,3'd0,8'h08,0,"R1 writer");
    issue(1,1,3,0,0,0,3'd0,8'h00,1,"R1 base");
    idle();
    issue(0,0,0,0,0,0,3'd0,8'h08,0,"R1 writer");
    issue(1,0,0,1,3,0,3'd0,8'h00,1,"R1 index");
    idle();
    issue(0,0,0,0,0,0,3'd0,8'h08,0,"R1 writer");
    issue(0,1,3,0,0,0,3'd0,8'h00,0,"R1 no addr use");
    issue(0,0,0,0,0,0,3'd0,8'h08,0,"R1 writer");
    issue(1,0,3,0,0,0,3'd0,8'h00,0,"R1 base invalid");
    // R2 LEA
    issue(0,0,0,0,0,0,3'd0,8'h40,0,"R2 writer");
    issue(0,0,0,1,6,0,3'd4,8'h01,1,"R2 lea");
    idle();
    // R3 explicit SP write
    issue(0,0,0,0,0,0,3'd0,8'h10,0,"R3 writer");
    issue(0,0,0,0,0,1,3'd1,8'h10,1,"R3 push");
    idle();
    // R4 predicted stack ops
    issue(0,0,0,0,0,1,3'd1,8'h10,0,"R4 push");
    issue(0,0,0,0,0,1,3'd1,8'h50,0,"R4 pop after push");
    issue(1,1,6,0,0,0,3'd0,8'h00,1,"R4 pop dest recorded");
    idle();
    // R5 plain RET
    issue(0,0,0,0,0,1,3'd2,8'h10,0,"R5 ret");
    issue(0,0,0,0,0,1,3'd1,8'h10,0,"R5 push after ret");
    idle();
    // R6 RET imm
    issue(0,0,0,0,0,1,3'd3,8'h00,0,"R6 reti");
    issue(0,0,0,0,0,1,3'd0,8'h00,1,"R6 sp user");
    idle();
    // R7 gap
    issue(0,0,0,0,0,0,3'd0,8'h04,0,"R7 writer");
    idle();
    issue(1,1,2,0,0,0,3'd0,8'h00,0,"R7 after bubble");
    issue(0,0,0,0,0,0,3'd0,8'h04,0,"R7 writer");
    issue(0,0,0,0,0,0,3'd0,8'h20,0,"R7 unrelated");
    issue(1,0,0,1,2,0,3'd0,8'h00,0,"R7 two back");
    // R8 stalled instruction's own writes
    issue(0,0,0,0,0,0,3'd0,8'h08,0,"R8 writer");
    issue(1,1,3,0,0,0,3'd0,8'h02,1,"R8 stalling load");
    issue(1,1,1,0,0,0,3'd0,8'h00,1,"R8 repeat writes kept");
    // R10 invalid slot
    issue(0,0,0,0,0,0,3'd0,8'h08,0,"R10 writer");
    @(negedge clk);
    in_valid = 0; addr_use = 1; base_vld = 1; base_id = 3; op_class = 0;
    #1 check("R10 invalid", stall, 1'b0);
    idle();
    idle();
    check("scoreboard drained", exp_q.size() != 0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule